// File: doc/BRIEF.md
# Nth-Chance Page Reclaim Sweeper

This block picks page frames to reclaim from a fixed pool. It approximates least-recently-used replacement. Each frame has a use flag and a small counter of idle visits. Any access to a frame raises its use flag through a one-cycle marking pulse that carries the frame index.

On a sweep request the engine latches a threshold N and walks a circular hand over the frames, one frame per clock:

- **Frame marked used:** the flag and the idle counter are both cleared, and the frame is kept.
- **Frame unused, counter below N:** the counter is aged by one, and the frame is kept.
- **Frame unused, counter at or above N:** the frame is named as the victim.

The hand keeps its position between requests. After a victim is named, the hand has already moved past it, so the next search starts at the following frame. With N = 0 the engine reclaims the first unused frame it meets, which is the plain clock scheme.

The controller has four states:

- **IDLE:** waits for a request. On `sweep_req`, the transition *start* leads to SCAN.
- **SCAN:** inspects one frame per clock. The transition *take* leads to HIT, the transition *exhaust* leads to MISS, and the transition *continue* stays in SCAN.
- **HIT:** presents the victim for one cycle, then the transition *report* returns to IDLE.
- **MISS:** presents the no-victim flag for one cycle, then the transition *report* returns to IDLE.

A scan that has made (N+1)·FRAMES inspections without a victim gives up (*exhaust*). This can only happen while marking pulses keep refreshing frames.

Top module: `nth_chance_sweeper`

## Requirements
- R1: After reset all use flags and idle counters are zero, the hand is at frame 0 and no output is active. A first sweep with N = 0 names frame 0 after exactly 1 inspection.
- R2: When the hand inspects a frame whose use flag is set, that flag and that frame's idle counter are cleared and the frame is kept.
- R3: When the hand inspects an unused frame whose counter is below N, the counter grows by one and the frame is kept. A counter is never aged past its maximum value.
- R4: When the hand inspects an unused frame whose counter is at least N, that frame is reported. `victim_valid` is high for exactly one cycle with `victim_idx`, following the edge of that inspection. `victim_valid` and `no_victim` are never both high.
- R5: The hand position is kept between sweeps. After a victim, the next sweep starts inspecting at the frame after the victim.
- R6: With N = 0 the first unused frame met is reclaimed, and only a frame with a clear use flag is ever taken.
- R7: The hand inspects one frame per clock in rising index order and wraps from frame FRAMES-1 to frame 0. A result inspected at the k-th inspection appears k cycles after the request edge.
- R8: If (N+1)·FRAMES inspections pass without a victim, `no_victim` is high for one cycle, and the hand ends where it started.
- R9: A marking pulse for the frame under inspection in that same cycle counts as a set use flag: the frame is kept and refreshed.
- R10: `sweep_req` is ignored while `busy` is high, and changes to `thresh_n` after the request edge do not affect the scan in progress. `busy` is high from the request edge until the report cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_set | input | 1 | Marks frame `use_idx` as used this cycle |
| use_idx | input | IDX_W | Frame index for `use_set` |
| sweep_req | input | 1 | Starts a victim search when idle |
| thresh_n | input | CNT_W | Threshold N, latched at the request |
| victim_valid | output | 1 | One-cycle pulse: a victim was found |
| victim_idx | output | IDX_W | Index of the reported victim |
| no_victim | output | 1 | One-cycle pulse: the search gave up |
| busy | output | 1 | A search or report is in progress |

## Verification
The assertions assume a few things about the inputs:

- `use_idx` names an existing frame whenever `use_set` is high.
- The pool holds at least two frames, so a reported victim can differ from the hand that has moved past it.
- The threshold stays within the counter range. Because of this, an aged counter can never have been at its maximum.

The stimulus keeps to these limits by design. Marking pulses are only ever issued for indices below the frame count. The threshold is taken from the counter width, and a single pulse at a time is driven on the marking input. Busy-time requests and threshold changes are applied deliberately, so that their lack of effect shows in the reported victim and in the inspection count.

// File: rtl/ncs_pkg.sv
package ncs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HIT,
        ST_MISS
    } ncs_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_REFRESH,
        ACT_AGE,
        ACT_TAKE
    } ncs_act_e;

endpackage

// File: rtl/ncs_frame_bank.sv
module ncs_frame_bank
    import ncs_pkg::*;
#(
    parameter int FRAMES = 8,
    parameter int CNT_W  = 3,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic [IDX_W-1:0]               set_idx,
    input  logic                           insp_en,
    input  logic [IDX_W-1:0]               insp_idx,
    input  ncs_act_e                       insp_act,
    output logic [FRAMES-1:0]              use_o,
    output logic [FRAMES-1:0][CNT_W-1:0]   cnt_o
);

    for (genvar g = 0; g < FRAMES; g++) begin : g_frame
        logic             use_r;
        logic [CNT_W-1:0] cnt_r;
        logic             here;
        logic             marked;

        assign here   = insp_en && (insp_idx == IDX_W'(g));
        assign marked = set_en && (set_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                use_r <= 1'b0;
                cnt_r <= '0;
            end else if (here) begin
                unique case (insp_act)
                    ACT_REFRESH: begin
                        use_r <= 1'b0;
                        cnt_r <= '0;
                    end
                    ACT_AGE:  cnt_r <= cnt_r + 1'b1;
                    ACT_TAKE: begin
                        use_r <= 1'b0;
                        cnt_r <= '0;
                    end
                    default: ;
                endcase
            end else if (marked) begin
                use_r <= 1'b1;
            end
        end

        assign use_o[g] = use_r;
        assign cnt_o[g] = cnt_r;

        // R3: ageing is only chosen for a counter below its maximum
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (here && insp_act == ACT_AGE) |-> (cnt_r != '1));

        // R6 / R9: a frame is only taken while unused and not being marked
        a_r6_take_only_unused: assert property (@(posedge clk) disable iff (!rst_n)
            (here && insp_act == ACT_TAKE) |-> (!use_r && !marked));
    end

endmodule

// File: rtl/ncs_sweep_ctrl.sv
module ncs_sweep_ctrl
    import ncs_pkg::*;
#(
    parameter int FRAMES = 8,
    parameter int CNT_W  = 3,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int BUD_W = CNT_W + IDX_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sweep_req,
    input  logic [CNT_W-1:0]               thresh_n,
    input  logic                           use_set,
    input  logic [IDX_W-1:0]               use_idx,
    input  logic [FRAMES-1:0]              use_vec,
    input  logic [FRAMES-1:0][CNT_W-1:0]   cnt_vec,
    output logic                           insp_en,
    output logic [IDX_W-1:0]               insp_idx,
    output ncs_act_e                       insp_act,
    output logic                           victim_valid,
    output logic [IDX_W-1:0]               victim_idx,
    output logic                           no_victim,
    output logic                           busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);
    localparam logic [BUD_W-1:0] FR_B     = BUD_W'(FRAMES);

    ncs_state_e       state_q, state_d;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] vic_q;
    logic [CNT_W-1:0] n_q;
    logic [BUD_W-1:0] bud_q;
    logic [BUD_W-1:0] lim_m1;
    logic             scanning;
    logic             seen_used;

    assign scanning  = (state_q == ST_SCAN);
    assign seen_used = use_vec[hand_q] || (use_set && use_idx == hand_q);
    assign lim_m1    = (({{(BUD_W-CNT_W){1'b0}}, n_q} + 1'b1) * FR_B) - 1'b1;

    // action for the frame under the hand
    always_comb begin
        insp_act = ACT_NONE;
        if (scanning) begin
            if (seen_used)                 insp_act = ACT_REFRESH;
            else if (cnt_vec[hand_q] >= n_q) insp_act = ACT_TAKE;
            else                           insp_act = ACT_AGE;
        end
    end

    assign insp_en  = scanning;
    assign insp_idx = hand_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sweep_req) state_d = ST_SCAN;          // start
            ST_SCAN: begin
                if (insp_act == ACT_TAKE)  state_d = ST_HIT;    // take
                else if (bud_q == lim_m1)  state_d = ST_MISS;   // exhaust
            end
            ST_HIT:  state_d = ST_IDLE;                         // report
            ST_MISS: state_d = ST_IDLE;                         // report
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // hand, budget, latched threshold, victim
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hand_q <= '0;
            vic_q  <= '0;
            n_q    <= '0;
            bud_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && sweep_req) begin
                n_q   <= thresh_n;
                bud_q <= '0;
            end
            if (scanning) begin
                hand_q <= (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
                bud_q  <= bud_q + 1'b1;
                if (insp_act == ACT_TAKE) vic_q <= hand_q;
            end
        end
    end

    // outputs
    always_comb begin
        victim_valid = 1'b0;
        no_victim    = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_SCAN: ;
            ST_HIT:  victim_valid = 1'b1;
            ST_MISS: no_victim = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign victim_idx = vic_q;

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(victim_valid && no_victim));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> (!victim_valid && !busy));

    a_r5_step_past: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand_q != victim_idx));

    a_r8_miss_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_victim) |-> $past(scanning));

endmodule

// File: rtl/nth_chance_sweeper.sv
module nth_chance_sweeper
    import ncs_pkg::*;
#(
    parameter int FRAMES = 8,
    parameter int CNT_W  = 3,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_set,
    input  logic [IDX_W-1:0] use_idx,
    input  logic             sweep_req,
    input  logic [CNT_W-1:0] thresh_n,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             no_victim,
    output logic             busy
);

    logic [FRAMES-1:0]            use_vec;
    logic [FRAMES-1:0][CNT_W-1:0] cnt_vec;
    logic                         insp_en;
    logic [IDX_W-1:0]             insp_idx;
    ncs_act_e                     insp_act;

    ncs_frame_bank #(.FRAMES(FRAMES), .CNT_W(CNT_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (use_set),
        .set_idx  (use_idx),
        .insp_en  (insp_en),
        .insp_idx (insp_idx),
        .insp_act (insp_act),
        .use_o    (use_vec),
        .cnt_o    (cnt_vec)
    );

    ncs_sweep_ctrl #(.FRAMES(FRAMES), .CNT_W(CNT_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sweep_req    (sweep_req),
        .thresh_n     (thresh_n),
        .use_set      (use_set),
        .use_idx      (use_idx),
        .use_vec      (use_vec),
        .cnt_vec      (cnt_vec),
        .insp_en      (insp_en),
        .insp_idx     (insp_idx),
        .insp_act     (insp_act),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .no_victim    (no_victim),
        .busy         (busy)
    );

endmodule

// File: tb/nth_chance_sweeper_tb.sv
module nth_chance_sweeper_tb_top;

    localparam int FRAMES = 8;
    localparam int CNT_W  = 3;
    localparam int IDX_W  = $clog2(FRAMES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             use_set = 1'b0;
    logic [IDX_W-1:0] use_idx = '0;
    logic             sweep_req = 1'b0;
    logic [CNT_W-1:0] thresh_n = '0;
    logic             victim_valid;
    logic [IDX_W-1:0] victim_idx;
    logic             no_victim;
    logic             busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the frame pool
    bit use_m [FRAMES];
    int cnt_m [FRAMES];
    int hand_m = 0;

    always #2 clk = ~clk;

    nth_chance_sweeper #(.FRAMES(FRAMES), .CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .use_set      (use_set),
        .use_idx      (use_idx),
        .sweep_req    (sweep_req),
        .thresh_n     (thresh_n),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .no_victim    (no_victim),
        .busy         (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mark(input int f);
        @(negedge clk);
        use_set = 1'b1;
        use_idx = IDX_W'(f);
        @(posedge clk);
        @(negedge clk);
        use_set = 1'b0;
        use_m[f] = 1'b1;
    endtask

    // chase: 0 none, 1 mark hand at first inspection, 2 mark hand every inspection
    task automatic sweep(input int n, input int chase, input bit disturb, input string req);
        int  k = 0;
        bit  done = 1'b0;
        bit  exp_hit = 1'b0;
        int  exp_vic = 0;
        bit  early = 1'b0;
        int  limit = (n + 1) * FRAMES;
        @(negedge clk);
        sweep_req = 1'b1;
        thresh_n  = CNT_W'(n);
        @(posedge clk);
        @(negedge clk);
        sweep_req = 1'b0;
        if (disturb) thresh_n = ~CNT_W'(n);
        while (!done && k < 600) begin
            int  f;
            bit  ch;
            k++;
            f  = hand_m;
            ch = (chase == 2) || (chase == 1 && k == 1);
            use_set = ch;
            use_idx = IDX_W'(f);
            if (disturb && k == 1) sweep_req = 1'b1;
            if (use_m[f] || ch) begin
                use_m[f] = 1'b0;
                cnt_m[f] = 0;
            end else if (cnt_m[f] >= n) begin
                use_m[f] = 1'b0;
                cnt_m[f] = 0;
                exp_hit = 1'b1;
                exp_vic = f;
                done = 1'b1;
            end else begin
                cnt_m[f]++;
            end
            hand_m = (hand_m + 1) % FRAMES;
            if (!done && k == limit) done = 1'b1;
            @(posedge clk);
            @(negedge clk);
            use_set   = 1'b0;
            sweep_req = 1'b0;
            if (!done && (victim_valid || no_victim)) early = 1'b1;
        end
        check(!early, {req, " R7 no early result"}, int'(early), 0);
        check(victim_valid == exp_hit, {req, " R4 victim_valid"}, int'(victim_valid), int'(exp_hit));
        check(no_victim == !exp_hit, {req, " R8 no_victim"}, int'(no_victim), int'(!exp_hit));
        if (exp_hit)
            check(int'(victim_idx) == exp_vic, {req, " R5 victim_idx"}, int'(victim_idx), exp_vic);
        @(posedge clk);
        @(negedge clk);
        check(!busy && !victim_valid && !no_victim, {req, " R10 idle after report"},
              int'({busy, victim_valid, no_victim}), 0);
    endtask

    initial begin
        for (int i = 0; i < FRAMES; i++) begin
            use_m[i] = 1'b0;
            cnt_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(!victim_valid && !no_victim && !busy, "R1 reset outputs",
              int'({busy, victim_valid, no_victim}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 idle after reset", int'(busy), 0);

        // R1 / R6: first sweep with N=0 takes frame 0 in one inspection
        sweep(0, 0, 1'b0, "R1 R6 first");

        // R2 R3 R4 R5 R7: patterned marks and thresholds, hand persists
        for (int p = 0; p < 28; p++) begin
            int mask = (p * 37 + 11) & 8'hFF;
            for (int f = 0; f < FRAMES; f++)
                if (mask[f]) mark(f);
            sweep(p % 4, 0, 1'b0, "R2 R3 pattern");
            if (p % 5 == 0) sweep(p % 3, 0, 1'b0, "R5 repeat");
        end

        // R9: mark collides with the inspected frame
        sweep(0, 1, 1'b0, "R9 same-cycle mark");
        sweep(2, 1, 1'b0, "R9 same-cycle mark N2");

        // R10: request and threshold change while busy
        sweep(1, 0, 1'b1, "R10 busy request");
        sweep(3, 0, 1'b1, "R10 busy request N3");

        // R8: marks chase the hand, search gives up
        sweep(1, 2, 1'b0, "R8 exhaust N1");
        sweep(0, 0, 1'b0, "R8 after exhaust");
        sweep(0, 2, 1'b0, "R8 exhaust N0");

        // R3: large threshold ages every frame to the top value
        sweep(7, 0, 1'b0, "R3 max threshold");
        sweep(7, 0, 1'b0, "R3 max threshold again");
        sweep(0, 0, 1'b0, "R6 clock mode");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule